// File: doc/BRIEF.md
# Compacted State Restore Sequencer

This block orders the restore of a set of processor state components from a save area in compacted layout. After a start pulse it captures a 64-bit request mask, the two enable registers (user-level and supervisor-level), the two save-area header masks (compaction format and state-present), the base address and the caller's privilege and guest flags. It then steps through components 0 up to the last one, one command per accepted handshake. Each command carries the component index, what to do with it (load from memory, reset to default, or leave alone) and the absolute byte address of its data.

Components 0 and 1 live in the fixed legacy region at the base address. Every later component sits after the 576-byte legacy-plus-header region. Its address is found by adding up the sizes of the lower components whose format bit is set. The block does no memory access and no fault checking. A downstream engine consumes the commands.

The block also keeps an in-use vector and a modified vector for the components. When the walk finishes, it records the privilege level, guest flag, base address and raw compaction mask of this restore.

Top module: `cmpct_restore_seq`

## Requirements
- R1: After reset, `busy`, `cmd_valid` and `done` are 0, and `inuse_vec`, `modified_vec` and all `info_*` outputs are 0.
- R2: The requested set is (user_en OR sup_en) AND req_mask. A component outside the requested set gets action code 0 (skip).
- R3: Action codes are 0 skip, 1 load, 2 init, and code 3 never appears. A component gets code 1 when its requested bit, its state-present bit and its format bit are all set. The format mask is hdr_fmt with bit 63 forced to 0.
- R4: A requested component that is not loaded gets code 2 (init). This covers a clear state-present bit or a clear format bit.
- R5: Components 0 and 1 carry address `base_addr`. Component i≥2 carries `base_addr` + 576 + the sum of the sizes of components 2..i-1 whose format bit is set. The load or init action does not affect this sum.
- R6: Commands come in ascending index order from 0 to NCOMP-1, one per cycle in which `cmd_valid` and `cmd_ready` are both high. A command stays stable while it is held.
- R7: An init command for component 1 carries 0x1F80 on `cmd_initword`. Every other command carries 0 there.
- R8: A load command sets that component's `inuse_vec` bit when accepted. An init command clears it. A skip leaves it unchanged.
- R9: In the cycle `done` is high, `modified_vec` equals NOT the requested set. It changes at no other time.
- R10: In the cycle `done` is high, `info_priv`, `info_guest`, `info_base` and `info_cmask` hold the captured privilege, guest flag, base address and unmodified compaction mask.
- R11: `done` is a one-cycle pulse in the cycle after the last command is accepted. In that cycle `busy` and `cmd_valid` are 0.
- R12: A `start` pulse while `busy` is high is ignored. The walk in progress keeps its captured inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a restore walk (accepted when idle) |
| req_mask | input | 64 | Request mask |
| user_en | input | 64 | User-level enabled components |
| sup_en | input | 64 | Supervisor-level enabled components |
| hdr_fmt | input | 64 | Header compaction-format mask |
| hdr_present | input | 64 | Header state-present mask |
| base_addr | input | ADDR_W | Linear base address of the save area |
| priv_lvl | input | PRIV_W | Current privilege level |
| guest_mode | input | 1 | Running as a virtualization guest |
| size_tbl | input | NCOMP*SIZE_W | Byte size of each component, entry i at bits i*SIZE_W |
| busy | output | 1 | Walk in progress |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Consumer accepts command |
| cmd_idx | output | IDX_W | Component index |
| cmd_act | output | 2 | Action code |
| cmd_addr | output | ADDR_W | Absolute address of the component data |
| cmd_initword | output | 32 | Default control/status word for an init |
| done | output | 1 | Walk complete pulse |
| inuse_vec | output | NCOMP | In-use tracking |
| modified_vec | output | NCOMP | Modified tracking |
| info_priv | output | PRIV_W | Recorded privilege level |
| info_guest | output | 1 | Recorded guest flag |
| info_base | output | ADDR_W | Recorded base address |
| info_cmask | output | 64 | Recorded raw compaction mask |

## Verification
The bench uses the default parameters: 63 components, 64-bit addresses and 32-bit sizes. This lets every component index, including the last one (62), appear in a walk. It also lets bit 63 of the compaction mask be set so the test can show that bit is ignored. Some component sizes are close to 2^32, so the running offset goes past 32 bits. This checks that a 32-bit size widens correctly into the 64-bit address sum. The `cmd_ready` signal is dropped at random, so commands are held for several cycles.

// File: rtl/crs_pkg.sv
package crs_pkg;
   typedef enum logic [1:0] {
      ACT_SKIP = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_INIT = 2'd2
   } crs_act_e;

   localparam logic [31:0] CRS_CSR_DEFAULT = 32'h0000_1F80;
   localparam int unsigned CRS_EXT_START   = 576;
endpackage

// File: rtl/crs_mask_calc.sv
module crs_mask_calc #(
   parameter int unsigned NCOMP  = 63,
   parameter int unsigned MASK_W = 64
) (
   input  logic [MASK_W-1:0] req_mask,
   input  logic [MASK_W-1:0] user_en,
   input  logic [MASK_W-1:0] sup_en,
   input  logic [MASK_W-1:0] hdr_fmt,
   input  logic [MASK_W-1:0] hdr_present,
   output logic [NCOMP-1:0]  rfbm,
   output logic [NCOMP-1:0]  fmt,
   output logic [NCOMP-1:0]  load_set,
   output logic [NCOMP-1:0]  init_set
);
   // The top bit of the format mask marks the layout, never a component.
   if (NCOMP >= MASK_W) begin : g_bad_width
      $error("crs_mask_calc: NCOMP must stay below MASK_W");
   end

   for (genvar g = 0; g < NCOMP; g++) begin : g_bit
      logic req_b;
      assign req_b       = (user_en[g] | sup_en[g]) & req_mask[g];
      assign rfbm[g]     = req_b;
      assign fmt[g]      = hdr_fmt[g];
      assign load_set[g] = req_b & hdr_fmt[g] & hdr_present[g];
      assign init_set[g] = (req_b & ~hdr_present[g]) | (req_b & ~hdr_fmt[g]);
   end
endmodule

// File: rtl/crs_walker.sv
module crs_walker #(
   parameter int unsigned NCOMP  = 63,
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned SIZE_W = 32,
   localparam int unsigned IDX_W = $clog2(NCOMP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              fire,
   input  logic              fmt_bit,
   input  logic [SIZE_W-1:0] cur_size,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] offset,
   output logic              walking,
   output logic              last_fire,
   output logic              done
);
   import crs_pkg::*;

   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NCOMP - 1);
   localparam logic [IDX_W-1:0]  FIRST_EXT = IDX_W'(2);
   localparam logic [ADDR_W-1:0] OFF_START = ADDR_W'(CRS_EXT_START);

   typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;
   walk_st_e st_q;

   logic [ADDR_W-1:0] size_ext;
   assign size_ext  = {{(ADDR_W-SIZE_W){1'b0}}, cur_size};
   assign walking   = (st_q == ST_WALK);
   assign last_fire = fire & walking & (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx    <= '0;
         offset <= OFF_START;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q   <= ST_WALK;
                  idx    <= '0;
                  offset <= OFF_START;
               end
            end
            ST_WALK: begin
               if (fire) begin
                  if (idx >= FIRST_EXT && fmt_bit)
                     offset <= offset + size_ext;
                  if (idx == LAST_IDX) begin
                     st_q <= ST_IDLE;
                     done <= 1'b1;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/crs_track.sv
module crs_track #(
   parameter int unsigned NCOMP  = 63,
   parameter int unsigned MASK_W = 64,
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned PRIV_W = 2,
   localparam int unsigned IDX_W = $clog2(NCOMP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              last_fire,
   input  logic [IDX_W-1:0]  idx,
   input  logic [1:0]        act,
   input  logic [NCOMP-1:0]  rfbm,
   input  logic [PRIV_W-1:0] priv_in,
   input  logic              guest_in,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [MASK_W-1:0] cmask_in,
   output logic [NCOMP-1:0]  inuse_vec,
   output logic [NCOMP-1:0]  modified_vec,
   output logic [PRIV_W-1:0] info_priv,
   output logic              info_guest,
   output logic [ADDR_W-1:0] info_base,
   output logic [MASK_W-1:0] info_cmask
);
   import crs_pkg::*;

   for (genvar g = 0; g < NCOMP; g++) begin : g_inuse
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            inuse_vec[g] <= 1'b0;
         end else if (fire && idx == IDX_W'(g)) begin
            if (act == ACT_LOAD)      inuse_vec[g] <= 1'b1;
            else if (act == ACT_INIT) inuse_vec[g] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         modified_vec <= '0;
         info_priv    <= '0;
         info_guest   <= 1'b0;
         info_base    <= '0;
         info_cmask   <= '0;
      end else if (last_fire) begin
         modified_vec <= ~rfbm;
         info_priv    <= priv_in;
         info_guest   <= guest_in;
         info_base    <= base_in;
         info_cmask   <= cmask_in;
      end
   end
endmodule

// File: rtl/cmpct_restore_seq.sv
module cmpct_restore_seq #(
   parameter int unsigned NCOMP  = 63,
   parameter int unsigned MASK_W = 64,
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned SIZE_W = 32,
   parameter int unsigned PRIV_W = 2,
   localparam int unsigned IDX_W = $clog2(NCOMP)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [MASK_W-1:0]       req_mask,
   input  logic [MASK_W-1:0]       user_en,
   input  logic [MASK_W-1:0]       sup_en,
   input  logic [MASK_W-1:0]       hdr_fmt,
   input  logic [MASK_W-1:0]       hdr_present,
   input  logic [ADDR_W-1:0]       base_addr,
   input  logic [PRIV_W-1:0]       priv_lvl,
   input  logic                    guest_mode,
   input  logic [NCOMP*SIZE_W-1:0] size_tbl,
   output logic                    busy,
   output logic                    cmd_valid,
   input  logic                    cmd_ready,
   output logic [IDX_W-1:0]        cmd_idx,
   output logic [1:0]              cmd_act,
   output logic [ADDR_W-1:0]       cmd_addr,
   output logic [31:0]             cmd_initword,
   output logic                    done,
   output logic [NCOMP-1:0]        inuse_vec,
   output logic [NCOMP-1:0]        modified_vec,
   output logic [PRIV_W-1:0]       info_priv,
   output logic                    info_guest,
   output logic [ADDR_W-1:0]       info_base,
   output logic [MASK_W-1:0]       info_cmask
);
   import crs_pkg::*;

   if (NCOMP < 3 || NCOMP >= MASK_W) begin : g_bad_ncomp
      $error("cmpct_restore_seq: NCOMP out of range");
   end
   if (ADDR_W <= SIZE_W) begin : g_bad_addr
      $error("cmpct_restore_seq: ADDR_W must exceed SIZE_W");
   end

   // Captured request
   logic [MASK_W-1:0] req_q, user_q, sup_q, fmt_q, pres_q;
   logic [ADDR_W-1:0] base_q;
   logic [PRIV_W-1:0] priv_q;
   logic              guest_q;
   logic              take;

   assign take = start & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= '0;
         user_q  <= '0;
         sup_q   <= '0;
         fmt_q   <= '0;
         pres_q  <= '0;
         base_q  <= '0;
         priv_q  <= '0;
         guest_q <= 1'b0;
      end else if (take) begin
         req_q   <= req_mask;
         user_q  <= user_en;
         sup_q   <= sup_en;
         fmt_q   <= hdr_fmt;
         pres_q  <= hdr_present;
         base_q  <= base_addr;
         priv_q  <= priv_lvl;
         guest_q <= guest_mode;
      end
   end

   logic [NCOMP-1:0] rfbm, fmt, load_set, init_set;

   crs_mask_calc #(.NCOMP(NCOMP), .MASK_W(MASK_W)) u_mask (
      .req_mask   (req_q),
      .user_en    (user_q),
      .sup_en     (sup_q),
      .hdr_fmt    (fmt_q),
      .hdr_present(pres_q),
      .rfbm       (rfbm),
      .fmt        (fmt),
      .load_set   (load_set),
      .init_set   (init_set)
   );

   // Size table unpacked per component
   logic [SIZE_W-1:0] size_arr [NCOMP];
   for (genvar g = 0; g < NCOMP; g++) begin : g_size
      assign size_arr[g] = size_tbl[g*SIZE_W +: SIZE_W];
   end

   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] offset;
   logic              walking, last_fire, fire;
   logic [SIZE_W-1:0] cur_size;
   logic              cur_fmt;

   assign cur_size = size_arr[idx];
   assign cur_fmt  = fmt[idx];
   assign fire     = walking & cmd_ready;

   crs_walker #(.NCOMP(NCOMP), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (take),
      .fire     (fire),
      .fmt_bit  (cur_fmt),
      .cur_size (cur_size),
      .idx      (idx),
      .offset   (offset),
      .walking  (walking),
      .last_fire(last_fire),
      .done     (done)
   );

   crs_act_e act;
   always_comb begin
      if (load_set[idx])      act = ACT_LOAD;
      else if (init_set[idx]) act = ACT_INIT;
      else                    act = ACT_SKIP;
   end

   assign busy         = walking;
   assign cmd_valid    = walking;
   assign cmd_idx      = idx;
   assign cmd_act      = act;
   assign cmd_addr     = (idx < IDX_W'(2)) ? base_q : base_q + offset;
   assign cmd_initword = (walking && act == ACT_INIT && idx == IDX_W'(1)) ?
                         CRS_CSR_DEFAULT : 32'h0;

   crs_track #(.NCOMP(NCOMP), .MASK_W(MASK_W), .ADDR_W(ADDR_W),
               .PRIV_W(PRIV_W)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (fire),
      .last_fire   (last_fire),
      .idx         (idx),
      .act         (act),
      .rfbm        (rfbm),
      .priv_in     (priv_q),
      .guest_in    (guest_q),
      .base_in     (base_q),
      .cmask_in    (fmt_q),
      .inuse_vec   (inuse_vec),
      .modified_vec(modified_vec),
      .info_priv   (info_priv),
      .info_guest  (info_guest),
      .info_base   (info_base),
      .info_cmask  (info_cmask)
   );
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
   parameter int unsigned NCOMP  = 63,
   parameter int unsigned ADDR_W = 64,
   localparam int unsigned IDX_W = $clog2(NCOMP)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [IDX_W-1:0]  cmd_idx,
   input logic [1:0]        cmd_act,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [31:0]       cmd_initword,
   input logic              done,
   input logic [NCOMP-1:0]  modified_vec
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCOMP - 1);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_idx) &&
                                   $stable(cmd_act) && $stable(cmd_addr));

   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && cmd_idx != LAST_IDX |=>
         cmd_valid && cmd_idx == $past(cmd_idx) + IDX_W'(1));

   p_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_act != 2'd3);

   p_initword_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_initword != 32'h0 |-> cmd_idx == IDX_W'(1) && cmd_act == 2'd2);

   p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && cmd_idx == LAST_IDX |=> done && !cmd_valid);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_mod_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      modified_vec != $past(modified_vec) |-> done);
endmodule

bind cmpct_restore_seq crs_checker #(.NCOMP(NCOMP), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_ready   (cmd_ready),
   .cmd_idx     (cmd_idx),
   .cmd_act     (cmd_act),
   .cmd_addr    (cmd_addr),
   .cmd_initword(cmd_initword),
   .done        (done),
   .modified_vec(modified_vec)
);

// File: tb/cmpct_restore_seq_tb_top.sv
`timescale 1ns/1ps
module cmpct_restore_seq_tb_top;
   localparam int NC = 63;
   localparam int SW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          start = 1'b0;
   logic [63:0]   req_mask = '0, user_en = '0, sup_en = '0, hdr_fmt = '0, hdr_present = '0;
   logic [63:0]   base_addr = '0;
   logic [1:0]    priv_lvl = '0;
   logic          guest_mode = 1'b0;
   logic [NC*SW-1:0] size_tbl = '0;
   logic          cmd_ready = 1'b0;
   logic          busy, cmd_valid, done, info_guest;
   logic [5:0]    cmd_idx;
   logic [1:0]    cmd_act;
   logic [63:0]   cmd_addr, info_base, info_cmask;
   logic [31:0]   cmd_initword;
   logic [NC-1:0] inuse_vec, modified_vec;
   logic [1:0]    info_priv;

   cmpct_restore_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .req_mask(req_mask),
      .user_en(user_en), .sup_en(sup_en), .hdr_fmt(hdr_fmt),
      .hdr_present(hdr_present), .base_addr(base_addr), .priv_lvl(priv_lvl),
      .guest_mode(guest_mode), .size_tbl(size_tbl), .busy(busy),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_idx(cmd_idx),
      .cmd_act(cmd_act), .cmd_addr(cmd_addr), .cmd_initword(cmd_initword),
      .done(done), .inuse_vec(inuse_vec), .modified_vec(modified_vec),
      .info_priv(info_priv), .info_guest(info_guest), .info_base(info_base),
      .info_cmask(info_cmask)
   );

   int checks = 0;
   int errors = 0;

   // Model copies of the captured request
   logic [63:0]   m_req, m_user, m_sup, m_fmt, m_pres, m_base;
   logic [1:0]    m_priv;
   logic          m_guest;
   logic [NC-1:0] m_inuse = '0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] f_rfbm();
      return (m_user | m_sup) & m_req;
   endfunction

   function automatic logic [1:0] f_act(input int i);
      logic [63:0] r, f;
      r = f_rfbm();
      f = m_fmt & 64'h7FFF_FFFF_FFFF_FFFF;
      if (r[i] && f[i] && m_pres[i]) return 2'd1;
      if (r[i] && (!m_pres[i] || !f[i])) return 2'd2;
      return 2'd0;
   endfunction

   function automatic logic [31:0] f_size(input int i);
      return size_tbl[i*SW +: SW];
   endfunction

   task automatic run_walk(input int ready_pct);
      logic [63:0] e_off;
      int          n_cmd;
      logic [63:0] exp_addr;
      m_req = req_mask; m_user = user_en; m_sup = sup_en; m_fmt = hdr_fmt;
      m_pres = hdr_present; m_base = base_addr; m_priv = priv_lvl; m_guest = guest_mode;
      e_off = 64'd576;
      n_cmd = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      forever begin
         cmd_ready = ($urandom_range(99) < ready_pct);
         if (n_cmd == 3) begin
            start = 1'b1; req_mask = ~req_mask; base_addr = base_addr ^ 64'h1000;
         end else begin
            start = 1'b0;
         end
         if (!cmd_valid) begin
            check("R6 valid during walk", {63'b0, cmd_valid}, 64'd1);
            break;
         end
         check("R6 index order", {58'b0, cmd_idx}, n_cmd);
         check("R2/R3/R4 action", {62'b0, cmd_act}, {62'b0, f_act(n_cmd)});
         exp_addr = (n_cmd < 2) ? m_base : m_base + e_off;
         check("R5 address", cmd_addr, exp_addr);
         check("R7 init word", {32'b0, cmd_initword},
               (n_cmd == 1 && f_act(1) == 2'd2) ? 64'h1F80 : 64'h0);
         if (cmd_ready) begin
            if (f_act(n_cmd) == 2'd1) m_inuse[n_cmd] = 1'b1;
            else if (f_act(n_cmd) == 2'd2) m_inuse[n_cmd] = 1'b0;
            if (n_cmd >= 2 && m_fmt[n_cmd]) e_off = e_off + {32'b0, f_size(n_cmd)};
            n_cmd++;
            if (n_cmd == NC) begin
               @(negedge clk);
               start = 1'b0; cmd_ready = 1'b0;
               break;
            end
         end
         @(negedge clk);
      end
      check("R11 done pulse", {63'b0, done}, 64'd1);
      check("R11 idle at done", {62'b0, busy, cmd_valid}, 64'd0);
      check("R12 stray start ignored (count)", n_cmd, NC);
      check("R9 modified", {1'b0, modified_vec}, {1'b0, ~f_rfbm()}[62:0]);
      check("R8 inuse", {1'b0, inuse_vec}, {1'b0, m_inuse});
      check("R10 info priv/guest", {61'b0, info_priv, info_guest}, {61'b0, m_priv, m_guest});
      check("R10 info base", info_base, m_base);
      check("R10 info cmask", info_cmask, m_fmt);
      @(negedge clk);
      check("R11 done single cycle", {63'b0, done}, 64'd0);
      check("R9 modified held", {1'b0, modified_vec}, {1'b0, ~f_rfbm()}[62:0]);
   endtask

   task automatic fill_sizes(input bit big);
      for (int i = 0; i < NC; i++) begin
         if (big && (i % 5 == 0)) size_tbl[i*SW +: SW] = 32'hFFFF_FFC0;
         else size_tbl[i*SW +: SW] = {$urandom_range(64), 6'b0};
      end
   endtask

   function automatic logic [63:0] r64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      #700000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset ctl", {61'b0, busy, cmd_valid, done}, 64'd0);
      check("R1 reset inuse/mod", {1'b0, inuse_vec | modified_vec}, 64'd0);
      check("R1 reset info", info_base | info_cmask | {61'b0, info_priv, info_guest}, 64'd0);

      fill_sizes(1'b0);
      base_addr = 64'h0000_1234_5678_0000; priv_lvl = 2'd0; guest_mode = 1'b1;
      // R3: everything loaded
      req_mask = '1; user_en = '1; sup_en = '0; hdr_fmt = '1; hdr_present = '1;
      run_walk(100);
      // R4: nothing present, all init (component 1 default word)
      req_mask = '1; hdr_present = '0; run_walk(60);
      // R4: format only bit 63 -> forced init; bit 63 never counts as a component
      hdr_fmt = 64'h8000_0000_0000_0000; hdr_present = '1; sup_en = '1; user_en = '0;
      run_walk(70);
      // R2: nothing requested -> all skip
      req_mask = '0; hdr_fmt = '1; run_walk(50);
      // R5: sizes that carry past 32 bits
      fill_sizes(1'b1);
      req_mask = '1; hdr_fmt = 64'h5555_5555_5555_5555; hdr_present = 64'hFFFF_0000_FFFF_0000;
      base_addr = 64'hFFFF_FFFF_0000_0000; priv_lvl = 2'd3; guest_mode = 1'b0;
      run_walk(80);
      // Random mix
      for (int t = 0; t < 20; t++) begin
         fill_sizes(t % 4 == 0);
         req_mask = r64(); user_en = r64(); sup_en = r64(); hdr_fmt = r64();
         hdr_present = r64(); base_addr = {r64()} & ~64'h3F;
         priv_lvl = 2'($urandom_range(3)); guest_mode = 1'($urandom_range(1));
         run_walk(40 + $urandom_range(60));
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule